// File: doc/BRIEF.md
# On-Screen Display Palette and Drop-Shadow Compositor

This block sits at the end of a display pipeline. Each pixel clock it takes one scaled video pixel, the pixel and line coordinates of that pixel, and a 4-bit palette index with a valid flag from an upstream menu generator. It combines them into one output pixel. A rectangular menu window is set by its origin and size. Inside the window, a valid index replaces the video with a colour from a 16-entry programmable palette. A palette entry is 12 bits wide and supplies only the top nibble of each 8-bit colour channel.

When the shadow is enabled, a rectangle of the same size as the window, moved 8 pixels right and 8 lines down, shows the video darkened to half intensity. Any window border width does not change where the shadow goes. The palette is loaded through a simple write strobe. Each cycle the compositor classifies the pixel into one of three source states, VIDEO, OSD or SHADOW, and holds that state in a register for one cycle. From the state register the output stage forms the pixel. Transitions can go from any state to any other on every clock: into OSD when the pixel is inside the window with a valid index, into SHADOW when it is in the offset rectangle, outside the window, with the shadow enabled, and into VIDEO in every other case.

Top module: `osd_overlay`

## Requirements
- R1: A synchronous active-low reset drives `pix_out` to zero and clears all 16 palette entries to zero.
- R2: A palette entry holds blue in bits 3:0, green in bits 7:4 and red in bits 11:8. In OSD state the output is {red nibble,0000, green nibble,0000, blue nibble,0000}, with red in `pix_out[23:16]`, green in [15:8] and blue in [7:0].
- R3: A write with `map_we` high at a clock edge stores `map_data` at `map_addr`. A pixel sampled at that same edge still sees the old entry, and a pixel sampled at the next edge sees the new one.
- R4: A pixel with `win_x <= pix_x < win_x+win_w` and `win_y <= pix_y < win_y+win_h` and `osd_vld` high enters OSD state and shows the palette colour of `osd_idx`.
- R5: Inside the window with `osd_vld` low, the video passes unchanged, even where the window covers the shadow rectangle. The window always has priority over the shadow.
- R6: With `shadow_en` high, a pixel outside the window that satisfies `win_x+8 <= pix_x < win_x+8+win_w` and `win_y+8 <= pix_y < win_y+8+win_h` enters SHADOW state. It shows each 8-bit video channel shifted right by one.
- R7: With `shadow_en` low, no pixel is darkened. Pixels in the shadow rectangle show the video unchanged.
- R8: `osd_vld` and `osd_idx` have no effect outside the window.
- R9: `pix_out` presents the result for the inputs sampled at the previous clock edge, a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_x | input | 12 | Pixel column of the current pixel |
| pix_y | input | 12 | Line number of the current pixel |
| win_x | input | 12 | Window left column |
| win_y | input | 12 | Window top line |
| win_w | input | 12 | Window width in pixels |
| win_h | input | 12 | Window height in lines |
| osd_vld | input | 1 | Palette index valid for this pixel |
| osd_idx | input | 4 | Palette index for this pixel |
| shadow_en | input | 1 | Enables the drop shadow |
| vid_in | input | 24 | Video pixel {R,G,B} |
| map_we | input | 1 | Palette write strobe |
| map_addr | input | 4 | Palette entry to write |
| map_data | input | 12 | Palette entry value {R,G,B} nibbles |
| pix_out | output | 24 | Composited pixel {R,G,B} |

## Verification
A corrupted palette entry appears only when a window pixel indexes it, exactly one cycle after that pixel. For this reason the stimulus reads every written entry back through window pixels, including in the cycle of the write. A wrong source state appears at the port on the next cycle, as a non-zero low nibble, an undimmed shadow pixel or a darkened window pixel. So the window edges and the shadow edges are each probed one pixel inside and one pixel outside, and random coordinates cover the overlap of window and shadow.

// File: rtl/osd_pkg.sv
package osd_pkg;
    typedef enum logic [1:0] {
        SRC_VIDEO  = 2'd0,
        SRC_OSD    = 2'd1,
        SRC_SHADOW = 2'd2
    } px_src_e;
endpackage

// File: rtl/osd_cmap.sv
module osd_cmap #(
    parameter int IDX_W = 4,
    parameter int ENT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [ENT_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [ENT_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [ENT_W-1:0] ent [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent[g] <= '0;
            else if (we && (waddr == IDX_W'(g)))
                ent[g] <= wdata;
        end
    end

    assign rdata = ent[raddr];
endmodule

// File: rtl/osd_region.sv
module osd_region
    import osd_pkg::*;
#(
    parameter int CRD_W   = 12,
    parameter int SHD_OFS = 8
) (
    input  logic [CRD_W-1:0] pix_x,
    input  logic [CRD_W-1:0] pix_y,
    input  logic [CRD_W-1:0] win_x,
    input  logic [CRD_W-1:0] win_y,
    input  logic [CRD_W-1:0] win_w,
    input  logic [CRD_W-1:0] win_h,
    input  logic             osd_vld,
    input  logic             shadow_en,
    output px_src_e          src
);
    localparam int EW = CRD_W + 2;

    logic [EW-1:0] px, py, wx0, wy0, wx1, wy1, sx0, sy0, sx1, sy1;
    logic          in_win, in_shd;

    always_comb begin
        px  = EW'(pix_x);
        py  = EW'(pix_y);
        wx0 = EW'(win_x);
        wy0 = EW'(win_y);
        wx1 = wx0 + EW'(win_w);
        wy1 = wy0 + EW'(win_h);
        sx0 = wx0 + EW'(SHD_OFS);
        sy0 = wy0 + EW'(SHD_OFS);
        sx1 = wx1 + EW'(SHD_OFS);
        sy1 = wy1 + EW'(SHD_OFS);
        in_win = (px >= wx0) && (px < wx1) && (py >= wy0) && (py < wy1);
        in_shd = (px >= sx0) && (px < sx1) && (py >= sy0) && (py < sy1);
    end

    always_comb begin
        if (in_win)
            src = osd_vld ? SRC_OSD : SRC_VIDEO;
        else if (shadow_en && in_shd)
            src = SRC_SHADOW;
        else
            src = SRC_VIDEO;
    end
endmodule

// File: rtl/osd_blend.sv
module osd_blend
    import osd_pkg::*;
#(
    parameter int CH_W  = 8,
    parameter int N_CH  = 3,
    parameter int HI_W  = CH_W / 2
) (
    input  px_src_e                 src,
    input  logic [N_CH*CH_W-1:0]    vid,
    input  logic [N_CH*HI_W-1:0]    ent,
    output logic [N_CH*CH_W-1:0]    pix
);
    localparam int LO_W = CH_W - HI_W;

    logic [N_CH*CH_W-1:0] osd_pix, half_pix;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        assign osd_pix[c*CH_W +: CH_W]  = {ent[c*HI_W +: HI_W], {LO_W{1'b0}}};
        assign half_pix[c*CH_W +: CH_W] = vid[c*CH_W +: CH_W] >> 1;
    end

    always_comb begin
        unique case (src)
            SRC_OSD:    pix = osd_pix;
            SRC_SHADOW: pix = half_pix;
            default:    pix = vid;
        endcase
    end
endmodule

// File: rtl/osd_overlay.sv
module osd_overlay
    import osd_pkg::*;
#(
    parameter int CRD_W   = 12,
    parameter int IDX_W   = 4,
    parameter int CH_W    = 8,
    parameter int SHD_OFS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CRD_W-1:0]  pix_x,
    input  logic [CRD_W-1:0]  pix_y,
    input  logic [CRD_W-1:0]  win_x,
    input  logic [CRD_W-1:0]  win_y,
    input  logic [CRD_W-1:0]  win_w,
    input  logic [CRD_W-1:0]  win_h,
    input  logic              osd_vld,
    input  logic [IDX_W-1:0]  osd_idx,
    input  logic              shadow_en,
    input  logic [3*CH_W-1:0] vid_in,
    input  logic              map_we,
    input  logic [IDX_W-1:0]  map_addr,
    input  logic [3*(CH_W/2)-1:0] map_data,
    output logic [3*CH_W-1:0] pix_out
);
    localparam int HI_W  = CH_W / 2;
    localparam int ENT_W = 3 * HI_W;
    localparam int PIX_W = 3 * CH_W;

    px_src_e          src_d, src_q;
    logic [ENT_W-1:0] ent_d, ent_q;
    logic [PIX_W-1:0] vid_q;

    osd_cmap #(.IDX_W(IDX_W), .ENT_W(ENT_W)) i_cmap (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (map_we),
        .waddr (map_addr),
        .wdata (map_data),
        .raddr (osd_idx),
        .rdata (ent_d)
    );

    osd_region #(.CRD_W(CRD_W), .SHD_OFS(SHD_OFS)) i_region (
        .pix_x     (pix_x),
        .pix_y     (pix_y),
        .win_x     (win_x),
        .win_y     (win_y),
        .win_w     (win_w),
        .win_h     (win_h),
        .osd_vld   (osd_vld),
        .shadow_en (shadow_en),
        .src       (src_d)
    );

    // source-state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= SRC_VIDEO;
            ent_q <= '0;
            vid_q <= '0;
        end else begin
            src_q <= src_d;
            ent_q <= ent_d;
            vid_q <= vid_in;
        end
    end

    // output stage
    osd_blend #(.CH_W(CH_W), .N_CH(3), .HI_W(HI_W)) i_blend (
        .src (src_q),
        .vid (vid_q),
        .ent (ent_q),
        .pix (pix_out)
    );
endmodule

// File: rtl/osd_overlay_chk.sv
module osd_overlay_chk #(
    parameter int CRD_W   = 12,
    parameter int IDX_W   = 4,
    parameter int CH_W    = 8,
    parameter int SHD_OFS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CRD_W-1:0]  pix_x,
    input logic [CRD_W-1:0]  pix_y,
    input logic [CRD_W-1:0]  win_x,
    input logic [CRD_W-1:0]  win_y,
    input logic [CRD_W-1:0]  win_w,
    input logic [CRD_W-1:0]  win_h,
    input logic              osd_vld,
    input logic [IDX_W-1:0]  osd_idx,
    input logic              shadow_en,
    input logic [3*CH_W-1:0] vid_in,
    input logic              map_we,
    input logic [IDX_W-1:0]  map_addr,
    input logic [3*(CH_W/2)-1:0] map_data,
    input logic [3*CH_W-1:0] pix_out
);
    localparam int EW   = CRD_W + 2;
    localparam int HI_W = CH_W / 2;

    logic win_hit, shd_hit, osd_hit, dim_hit;
    logic                last_we_q;
    logic [IDX_W-1:0]    last_addr_q;
    logic [3*HI_W-1:0]   last_data_q;
    logic [3*CH_W-1:0]   half_v, exp_ent;

    assign win_hit = (EW'(pix_x) >= EW'(win_x)) && (EW'(pix_x) < EW'(win_x) + EW'(win_w))
                  && (EW'(pix_y) >= EW'(win_y)) && (EW'(pix_y) < EW'(win_y) + EW'(win_h));
    assign shd_hit = (EW'(pix_x) >= EW'(win_x) + EW'(SHD_OFS))
                  && (EW'(pix_x) < EW'(win_x) + EW'(win_w) + EW'(SHD_OFS))
                  && (EW'(pix_y) >= EW'(win_y) + EW'(SHD_OFS))
                  && (EW'(pix_y) < EW'(win_y) + EW'(win_h) + EW'(SHD_OFS));
    assign osd_hit = win_hit && osd_vld;
    assign dim_hit = !win_hit && shd_hit && shadow_en;

    assign half_v  = {1'b0, vid_in[23:17], 1'b0, vid_in[15:9], 1'b0, vid_in[7:1]};
    assign exp_ent = {last_data_q[11:8], 4'h0, last_data_q[7:4], 4'h0, last_data_q[3:0], 4'h0};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_we_q   <= 1'b0;
            last_addr_q <= '0;
            last_data_q <= '0;
        end else begin
            last_we_q   <= map_we;
            last_addr_q <= map_addr;
            last_data_q <= map_data;
        end
    end

    // R2
    osd_low_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osd_hit |=> (pix_out[19:16] == 4'h0) && (pix_out[11:8] == 4'h0) && (pix_out[3:0] == 4'h0));

    // R6
    shadow_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dim_hit |=> pix_out == $past(half_v));

    // R5
    video_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!osd_hit && !dim_hit) |=> pix_out == $past(vid_in));

    // R3
    map_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_we_q && osd_hit && (osd_idx == last_addr_q)) |=> pix_out == $past(exp_ent));
endmodule

bind osd_overlay osd_overlay_chk #(
    .CRD_W(CRD_W), .IDX_W(IDX_W), .CH_W(CH_W), .SHD_OFS(SHD_OFS)
) i_osd_overlay_chk (
    .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
    .win_x(win_x), .win_y(win_y), .win_w(win_w), .win_h(win_h),
    .osd_vld(osd_vld), .osd_idx(osd_idx), .shadow_en(shadow_en),
    .vid_in(vid_in), .map_we(map_we), .map_addr(map_addr),
    .map_data(map_data), .pix_out(pix_out)
);

// File: tb/test_osd_overlay.sv
module test_osd_overlay;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] pix_x = '0, pix_y = '0, win_x = '0, win_y = '0, win_w = '0, win_h = '0;
    logic        osd_vld = 1'b0;
    logic [3:0]  osd_idx = '0;
    logic        shadow_en = 1'b0;
    logic [23:0] vid_in = '0;
    logic        map_we = 1'b0;
    logic [3:0]  map_addr = '0;
    logic [11:0] map_data = '0;
    logic [23:0] pix_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [11:0] model [16];

    osd_overlay i_osd_overlay (
        .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
        .win_x(win_x), .win_y(win_y), .win_w(win_w), .win_h(win_h),
        .osd_vld(osd_vld), .osd_idx(osd_idx), .shadow_en(shadow_en),
        .vid_in(vid_in), .map_we(map_we), .map_addr(map_addr),
        .map_data(map_data), .pix_out(pix_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [23:0] expect_pix();
        int x = pix_x, y = pix_y, wx = win_x, wy = win_y, ww = win_w, wh = win_h;
        bit inw = (x >= wx) && (x < wx + ww) && (y >= wy) && (y < wy + wh);
        bit ins = (x >= wx + 8) && (x < wx + ww + 8) && (y >= wy + 8) && (y < wy + wh + 8);
        logic [11:0] e = model[osd_idx];
        if (inw && osd_vld) return {e[11:8], 4'h0, e[7:4], 4'h0, e[3:0], 4'h0};
        if (!inw && ins && shadow_en)
            return {vid_in[23:16] >> 1, vid_in[15:8] >> 1, vid_in[7:0] >> 1};
        return vid_in;
    endfunction

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
        end
    endtask

    // inputs already set at a falling edge; result is checked one cycle later
    task automatic step(input string req);
        logic [23:0] exp = expect_pix();
        @(posedge clk);
        if (map_we) model[map_addr] = map_data;
        @(negedge clk);
        check(req, pix_out, exp);
        map_we = 1'b0;
    endtask

    task automatic px(input int x, input int y, input bit v, input int idx,
                      input bit sh, input logic [23:0] vid);
        pix_x = 12'(x); pix_y = 12'(y); osd_vld = v; osd_idx = 4'(idx);
        shadow_en = sh; vid_in = vid;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int r;
        r = $urandom(32'd4242);
        foreach (model[i]) model[i] = '0;
        vid_in = 24'hFFFFFF;
        repeat (3) @(negedge clk);
        check("R1 reset output", pix_out, 24'h0);
        rst_n = 1'b1;

        win_x = 12'd10; win_y = 12'd20; win_w = 12'd16; win_h = 12'd12;

        // R1: palette cleared by reset
        px(10, 20, 1, 5, 0, 24'h123456); step("R1 palette cleared");

        // R3: write and read the same entry in the same cycle
        px(11, 21, 1, 7, 0, 24'h777777);
        map_we = 1'b1; map_addr = 4'd7; map_data = 12'h123;
        step("R3 same-cycle old entry");
        px(11, 21, 1, 7, 0, 24'h777777); step("R3 next-cycle new entry");

        // R2: channel layout
        map_we = 1'b1; map_addr = 4'd3; map_data = 12'hA5C; px(0, 0, 0, 0, 0, 24'h0);
        step("R9 video outside");
        px(10, 20, 1, 3, 1, 24'hFFFFFF); step("R2 nibble layout top-left");
        px(25, 31, 1, 3, 1, 24'hFFFFFF); step("R4 last inside corner");
        px(26, 20, 1, 3, 1, 24'h808080); step("R8 right of window");
        px(25, 32, 1, 3, 0, 24'h808080); step("R4 below window");
        px(5, 5, 1, 3, 1, 24'h445566);   step("R8 index outside window");

        // R5: window over shadow overlap
        px(20, 29, 1, 3, 1, 24'hFEFEFE); step("R5 window wins overlap");
        px(20, 29, 0, 3, 1, 24'hFEFEFE); step("R5 transparent window over shadow");

        // R6: shadow area x 18..33, y 28..39
        px(26, 28, 0, 0, 1, 24'hFF8001); step("R6 shadow top-left outside window");
        px(33, 39, 0, 0, 1, 24'h0F0F0F); step("R6 shadow last corner");
        px(34, 39, 0, 0, 1, 24'h0F0F0F); step("R6 right of shadow");
        px(33, 40, 0, 0, 1, 24'h0F0F0F); step("R6 below shadow");
        px(17, 35, 0, 0, 1, 24'h0F0F0F); step("R6 left of shadow");
        px(26, 28, 0, 0, 0, 24'hFF8001); step("R7 shadow disabled");

        // R9: back-to-back mixed sources
        px(12, 22, 1, 7, 1, 24'h0); step("R9 osd then");
        px(30, 35, 1, 7, 1, 24'hAAAAAA); step("R9 shadow then");
        px(40, 40, 1, 7, 1, 24'h135790); step("R9 video");

        // random mix
        for (int n = 0; n < N_RAND; n++) begin
            if (($urandom % 8) == 0) begin
                win_x = 12'($urandom % 40); win_y = 12'($urandom % 40);
                win_w = 12'($urandom % 20); win_h = 12'($urandom % 20);
            end
            map_we = ($urandom % 4) == 0;
            map_addr = 4'($urandom); map_data = 12'($urandom);
            px($urandom % 72, $urandom % 72, $urandom % 2, $urandom % 16,
               ($urandom % 4) != 0, 24'($urandom));
            step("R4/R6/R8 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule